// File: doc/BRIEF.md
# Four-Channel Shared-Bus DMA Arbiter

This block decides which of four DMA channels owns the one shared bus. Each channel raises a request line. The arbiter returns a one-hot grant, and that grant stays put until the granted channel signals that it has finished its transfer unit. At that boundary the arbiter chooses again. The choice follows a 2-bit priority mode. Three modes are fixed rankings and the fourth rotates the channels so that each gets a fair turn.

A small operation register holds the global run controls: a master enable bit, the priority mode, and two sticky fault flags. The NMI input sets the NMI flag. An address-error pulse from any channel sets the address-error flag. If either flag is set, or if the enable bit is clear, all bus activity stops. The arbiter then drives the grant to zero and lowers the master-enable output to every channel. Software clears a fault flag by writing 0 to it. Writing 1 to a flag leaves it unchanged.

Top module: `dma_bus_arbiter`

## Requirements
- R1: With mode 2'b00 the idle arbiter grants the requesting channel with the best rank in the order 0, 1, 2, 3. `grant[i]` stands for channel i.
- R2: With mode 2'b01 the ranking is 0, 2, 3, 1.
- R3: With mode 2'b10 the ranking is 2, 0, 1, 3.
- R4: Mode 2'b11 rotates the ranking. The channel served most recently becomes the lowest rank. After reset the ranking is 0, 1, 2, 3.
- R5: While the enable bit (`cfg_enable` as last written) is 0, `grant` is zero from the next clock edge onward.
- R6: A high `nmi` sets `nmi_flag`, and any high bit of `addr_err` sets `ae_flag`, at the next edge. When `cfg_we` is high, `cfg_nmi_wr` = 0 clears `nmi_flag` and `cfg_ae_wr` = 0 clears `ae_flag`. Writing 1 to either leaves the flag unchanged. A set and a clear on the same edge leave the flag set.
- R7: `master_en` equals enable AND NOT `ae_flag` AND NOT `nmi_flag`. When `master_en` is low, `grant` is zero from the next edge onward, even with the enable bit at 1.
- R8: A grant is held until its own `done` bit is high at a clock edge. A `done` pulse from any other channel has no effect. On the edge where the unit ends, the next winner is chosen from the current requests.
- R9: `grant` has at most one bit set and changes only at a clock edge. After reset, `grant`, `ae_flag`, `nmi_flag` and `master_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the operation register |
| cfg_enable | input | 1 | Master enable value to write |
| cfg_mode | input | 2 | Priority mode value to write |
| cfg_ae_wr | input | 1 | 0 clears the address-error flag, 1 keeps it |
| cfg_nmi_wr | input | 1 | 0 clears the NMI flag, 1 keeps it |
| req | input | 4 | Channel bus requests |
| done | input | 4 | Per-channel end-of-unit pulse |
| addr_err | input | 4 | Per-channel address-error pulse |
| nmi | input | 1 | Non-maskable interrupt event |
| grant | output | 4 | One-hot bus grant |
| master_en | output | 1 | Run permission to all channels |
| ae_flag | output | 1 | Sticky address-error flag |
| nmi_flag | output | 1 | Sticky NMI flag |

## Verification
Request sets with all four channels active show the top of each fixed ranking. Sparse pairs of channels separate adjacent ranks, for example channels 1 and 3 under mode 2'b01, where 3 must win. A fully loaded rotation sequence distinguishes round-robin from every fixed order, and a first rotating grant right after reset confirms where the rotation starts. Fault pulses arriving in the middle of a unit separate an immediate global halt from a halt that waits for the unit to end. Unit-end pulses from channels that do not hold the grant confirm that only the owner can release the bus.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [1:0] {
    PRI_LINEAR = 2'b00,
    PRI_ZERO_TWO = 2'b01,
    PRI_TWO_FIRST = 2'b10,
    PRI_ROTATE = 2'b11
  } pri_mode_e;

  // channel sitting at rank k (0 = best) for a given mode
  function automatic logic [CW-1:0] rank_slot(input pri_mode_e mode,
                                              input logic [CW-1:0] last,
                                              input int unsigned k);
    logic [CW-1:0] kk;
    kk = CW'(k);
    case (mode)
      PRI_LINEAR:    rank_slot = kk;
      PRI_ZERO_TWO:  rank_slot = (kk == 0) ? CW'(0) : (kk == 3) ? CW'(1) : CW'(kk + 1);
      PRI_TWO_FIRST: rank_slot = (kk == 0) ? CW'(2) : (kk == 3) ? CW'(3) : CW'(kk - 1);
      default:       rank_slot = CW'(last + kk + 1);
    endcase
  endfunction

  function automatic logic [CW-1:0] onehot_index(input logic [NCH-1:0] v);
    onehot_index = '0;
    for (int i = 0; i < NCH; i++) if (v[i]) onehot_index = CW'(i);
  endfunction
endpackage

// File: rtl/dma_arb_ctrl_reg.sv
module dma_arb_ctrl_reg
  import dma_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_enable,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_ae_wr,
  input  logic           cfg_nmi_wr,
  input  logic [NCH-1:0] addr_err,
  input  logic           nmi,
  output logic           enable_q,
  output pri_mode_e      mode_q,
  output logic           ae_q,
  output logic           nmi_q,
  output logic           run
);
  logic ae_set, nmi_set;
  assign ae_set  = |addr_err;
  assign nmi_set = nmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      mode_q   <= PRI_LINEAR;
      ae_q     <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      if (cfg_we) begin
        enable_q <= cfg_enable;
        mode_q   <= pri_mode_e'(cfg_mode);
      end
      ae_q  <= ae_set  | (ae_q  & ~(cfg_we & ~cfg_ae_wr));
      nmi_q <= nmi_set | (nmi_q & ~(cfg_we & ~cfg_nmi_wr));
    end
  end

  assign run = enable_q & ~ae_q & ~nmi_q;

  a_r6_nmi_sets: assert property (@(posedge clk) disable iff (!rst_n) nmi_set |=> nmi_q);
  a_r6_ae_sets:  assert property (@(posedge clk) disable iff (!rst_n) ae_set |=> ae_q);
  a_r6_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !(cfg_we && !cfg_nmi_wr)) |=> nmi_q);
endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select
  import dma_arb_pkg::*;
(
  input  pri_mode_e      mode,
  input  logic [CW-1:0]  last,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] sel
);
  logic [CW-1:0] slot [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_rank
    assign slot[k] = rank_slot(mode, last, k);
  end

  always_comb begin
    sel = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (req[slot[k]]) begin
        sel = '0;
        sel[slot[k]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_enable,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_ae_wr,
  input  logic       cfg_nmi_wr,
  input  logic [3:0] req,
  input  logic [3:0] done,
  input  logic [3:0] addr_err,
  input  logic       nmi,
  output logic [3:0] grant,
  output logic       master_en,
  output logic       ae_flag,
  output logic       nmi_flag
);
  logic           enable_q, run;
  pri_mode_e      mode_q;
  logic [NCH-1:0] grant_q, sel, grant_d;
  logic [CW-1:0]  last_q;
  logic           idle, unit_end, issue;

  dma_arb_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_ae_wr(cfg_ae_wr), .cfg_nmi_wr(cfg_nmi_wr),
    .addr_err(addr_err), .nmi(nmi), .enable_q(enable_q), .mode_q(mode_q),
    .ae_q(ae_flag), .nmi_q(nmi_flag), .run(run)
  );

  dma_arb_select u_sel (.mode(mode_q), .last(last_q), .req(req), .sel(sel));

  // named events for the assertions
  assign idle     = (grant_q == '0);
  assign unit_end = |(grant_q & done);
  assign issue    = run && (idle || unit_end) && (sel != '0);

  always_comb begin
    grant_d = grant_q;
    if (!run)                 grant_d = '0;
    else if (idle || unit_end) grant_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= CW'(NCH - 1);
    end else begin
      grant_q <= grant_d;
      if (issue) last_q <= onehot_index(sel);
    end
  end

  assign grant     = grant_q;
  assign master_en = run;

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_q));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !idle && !unit_end) |=> $stable(grant_q));
  a_r8_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idle && req != '0) |=> (grant_q != '0));
  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_flag || nmi_flag) |=> (grant_q == '0));
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |=> (grant_q == '0));
  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ((grant_q & $past(req)) != '0));
endmodule

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_enable = 0, cfg_ae_wr = 1, cfg_nmi_wr = 1;
  logic [1:0] cfg_mode = 0;
  logic [3:0] req = 0, done = 0, addr_err = 0, grant;
  logic nmi = 0, master_en, ae_flag, nmi_flag;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_ae_wr(cfg_ae_wr), .cfg_nmi_wr(cfg_nmi_wr),
    .req(req), .done(done), .addr_err(addr_err), .nmi(nmi),
    .grant(grant), .master_en(master_en), .ae_flag(ae_flag), .nmi_flag(nmi_flag)
  );

  // {mode, req, expected grant} from idle
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {2'b00, 4'b1111, 4'b0001}, {2'b00, 4'b1100, 4'b0100}, {2'b00, 4'b1010, 4'b0010},
    {2'b01, 4'b1111, 4'b0001}, {2'b01, 4'b1110, 4'b0100}, {2'b01, 4'b1010, 4'b1000},
    {2'b01, 4'b0010, 4'b0010}, {2'b10, 4'b1111, 4'b0100}, {2'b10, 4'b1011, 4'b0001},
    {2'b10, 4'b1010, 4'b0010}, {2'b10, 4'b1000, 4'b1000}, {2'b00, 4'b0000, 4'b0000}
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic en, logic [1:0] m, logic ae_w, logic nmi_w);
    cfg_we = 1; cfg_enable = en; cfg_mode = m; cfg_ae_wr = ae_w; cfg_nmi_wr = nmi_w;
    tick();
    cfg_we = 0; cfg_ae_wr = 1; cfg_nmi_wr = 1;
  endtask

  task automatic end_unit(logic [3:0] ch, logic [3:0] next_req);
    done = ch; req = next_req; tick(); done = 0;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R9 reset grant", grant, 0);
    chk("R9 reset flags", {ae_flag, nmi_flag, master_en}, 0);
    rst_n = 1; tick();

    // R5: enable 0, requests pending
    req = 4'b1111; tick(3);
    chk("R5 disabled no grant", grant, 0);
    chk("R7 master_en low when disabled", master_en, 0);
    req = 0;

    // R1/R2/R3 table
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m; logic [3:0] r, e;
      {m, r, e} = VEC[v];
      wr(1'b1, m, 1'b1, 1'b1);
      req = r; tick();
      chk(m == 2'b00 ? "R1 fixed order 0123" : m == 2'b01 ? "R2 fixed order 0231"
          : "R3 fixed order 2013", grant, e);
      end_unit(e, 4'b0000);
    end
    chk("R7 master_en high when running", master_en, 1);

    // R8: hold, foreign done ignored, reissue on own done
    wr(1'b1, 2'b00, 1'b1, 1'b1);
    req = 4'b0010; tick();
    chk("R8 initial grant", grant, 4'b0010);
    req = 4'b0011; tick(3);
    chk("R8 held despite better request", grant, 4'b0010);
    done = 4'b0101; tick(); done = 0;
    chk("R8 foreign done ignored", grant, 4'b0010);
    end_unit(4'b0010, 4'b0001);
    chk("R8 reissue on own done", grant, 4'b0001);
    end_unit(4'b0001, 4'b0000);

    // R6/R7: NMI mid-unit
    req = 4'b0100; tick();
    chk("R8 grant before nmi", grant, 4'b0100);
    nmi = 1; tick(); nmi = 0;
    chk("R6 nmi flag set", nmi_flag, 1);
    chk("R7 master_en drops", master_en, 0);
    tick();
    chk("R7 grant halted by nmi", grant, 0);
    wr(1'b1, 2'b00, 1'b1, 1'b1);
    chk("R6 writing 1 keeps nmi flag", nmi_flag, 1);
    tick(2);
    chk("R7 still halted", grant, 0);
    wr(1'b1, 2'b00, 1'b1, 1'b0);
    chk("R6 nmi cleared by 0", nmi_flag, 0);
    tick();
    chk("R7 resumes after clear", grant, 4'b0100);

    // R6/R7: address error, set wins over same-edge clear
    addr_err = 4'b1000; cfg_we = 1; cfg_enable = 1; cfg_mode = 0; cfg_ae_wr = 0;
    tick(); addr_err = 0; cfg_we = 0; cfg_ae_wr = 1;
    chk("R6 ae set wins over clear", ae_flag, 1);
    tick();
    chk("R7 grant halted by address error", grant, 0);
    wr(1'b1, 2'b00, 1'b0, 1'b1);
    chk("R6 ae cleared by 0", ae_flag, 0);
    req = 0; tick();
    wr(1'b1, 2'b00, 1'b1, 1'b1);
    tick();
    chk("R6 writing 1 does not set ae", ae_flag, 0);
    end_unit(grant, 4'b0000);

    // R4: rotation from reset
    rst_n = 0; tick(); rst_n = 1; tick();
    wr(1'b1, 2'b11, 1'b1, 1'b1);
    req = 4'b1010; tick();
    chk("R4 first rotating grant", grant, 4'b0010);
    end_unit(4'b0010, 4'b1111);
    chk("R4 after ch1", grant, 4'b0100);
    end_unit(4'b0100, 4'b1111);
    chk("R4 after ch2", grant, 4'b1000);
    end_unit(4'b1000, 4'b1111);
    chk("R4 after ch3", grant, 4'b0001);
    end_unit(4'b0001, 4'b1011);
    chk("R4 after ch0 skip idle ch2", grant, 4'b0010);
    end_unit(4'b0010, 4'b0000);
    chk("R9 grant zero with no requests", grant, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule